// File: doc/BRIEF.md
# Masked Vector-Scalar Signed Maximum Unit

This unit takes one packed vector operand and one scalar integer and, lane by lane, keeps whichever of the two is larger under signed two's-complement ordering. The lane width is chosen per operation from 8, 16, 32 or 64 bits. The number of lanes is the vector width divided by that lane width. The scalar comes from a 64-bit integer register. It is cut down to the lane width, or sign-extended if the lane width were ever wider than the register.

A vector length input splits the lanes into two groups. Lanes below the length form the body, and the rest form the tail. An enable bit and a per-lane mask word decide which body lanes are computed. Lanes that are not computed are filled from the old destination contents or set to all ones. Two separate policy bits control this fill: one for masked-off body lanes and one for tail lanes. The operation never traps.

The result is registered. It appears with a valid pulse one cycle after the input valid, and it holds until the next operation.

Top module: `vsmax_unit`

## Requirements
- R1: Each active lane of the result is the signed maximum of the vector lane and the adapted scalar, at exactly the lane width, with no overflow and no trap.
- R2: The lane width code is 2'b00=8, 2'b01=16, 2'b10=32 and 2'b11=64 bits. The lane count is the vector width divided by the lane width, and lane i occupies bits [i*EW +: EW].
- R3: When `mask_en_n_i` is 0, lane i is active only when bit i of `mask_i` is 1. When it is 1, every body lane is active.
- R4: A lane with index at or above `vlen_i` is a tail lane. With `tail_fill_i`=0 it keeps its `old_i` value, and with 1 it becomes all ones. `vlen_i`=0 makes every lane a tail lane. A length above the lane count acts as the lane count.
- R5: An inactive body lane keeps its `old_i` value when `inact_fill_i`=0 and becomes all ones when it is 1.
- R6: For lane widths narrower than 64 bits, only the low lane-width bits of `scalar_i` are used as a signed value. At 64 bits, all scalar bits are used.
- R7: `out_valid_o` is high exactly in the cycle after a cycle with `in_valid_i` high. `vd_o` changes only after an accepted input and otherwise holds.
- R8: After reset, `out_valid_o` is 0 and `vd_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| in_valid_i | input | 1 | operation request |
| src_i | input | VLEN | packed vector operand |
| scalar_i | input | XLEN | scalar integer operand |
| old_i | input | VLEN | previous destination contents |
| mask_i | input | VLEN | per-lane mask, bit i for lane i |
| mask_en_n_i | input | 1 | 0 = apply mask, 1 = unmasked |
| vlen_i | input | VL_W | vector length in lanes |
| sew_i | input | 2 | lane width code |
| tail_fill_i | input | 1 | tail policy, 1 = all ones |
| inact_fill_i | input | 1 | inactive-lane policy, 1 = all ones |
| out_valid_o | output | 1 | result valid, one cycle after request |
| vd_o | output | VLEN | packed result |

## Verification
The assertions assume that reset has been applied before the first request and that every input is stable and known in any cycle where `in_valid_i` is high. The 64-bit lane check assumes that lane 0 is in the body, which means `vlen_i` is at least 1. The bench drives all inputs on the falling edge, raises the request for exactly one cycle per operation, and always gives a length that fits the length port. It also includes cases with lengths beyond the lane count, so that clamping is exercised without leaving the port range.

// File: rtl/vsmax_pkg.sv
package vsmax_pkg;
    typedef enum logic [1:0] {
        SEW_E8  = 2'b00,
        SEW_E16 = 2'b01,
        SEW_E32 = 2'b10,
        SEW_E64 = 2'b11
    } sew_e;

    localparam int NUM_SEW = 4;
    localparam int MIN_EW  = 8;

    function automatic int lane_bits(int code);
        return MIN_EW << code;
    endfunction
endpackage

// File: rtl/vsmax_lane.sv
module vsmax_lane #(
    parameter int EW = 8
) (
    input  logic [EW-1:0] elem_i,
    input  logic [EW-1:0] scal_i,
    input  logic [EW-1:0] old_i,
    input  logic          body_i,
    input  logic          active_i,
    input  logic          tail_fill_i,
    input  logic          inact_fill_i,
    output logic [EW-1:0] res_o
);
    logic [EW-1:0] max_v;

    always_comb begin
        max_v = ($signed(elem_i) < $signed(scal_i)) ? scal_i : elem_i;
        if (!body_i)
            res_o = tail_fill_i ? {EW{1'b1}} : old_i;
        else if (!active_i)
            res_o = inact_fill_i ? {EW{1'b1}} : old_i;
        else
            res_o = max_v;
    end
endmodule

// File: rtl/vsmax_sew_group.sv
module vsmax_sew_group #(
    parameter int VLEN = 256,
    parameter int XLEN = 64,
    parameter int EW   = 8,
    parameter int VL_W = 6
) (
    input  logic [VLEN-1:0] src_i,
    input  logic [XLEN-1:0] scalar_i,
    input  logic [VLEN-1:0] old_i,
    input  logic [VLEN-1:0] mask_i,
    input  logic            mask_en_n_i,
    input  logic [VL_W-1:0] vlen_i,
    input  logic            tail_fill_i,
    input  logic            inact_fill_i,
    output logic [VLEN-1:0] res_o
);
    localparam int NE = VLEN / EW;

    logic [EW-1:0] scal;

    generate
        if (EW < XLEN) begin : g_trunc
            logic unused_hi;
            assign scal      = scalar_i[EW-1:0];
            assign unused_hi = ^scalar_i[XLEN-1:EW];
        end else if (EW == XLEN) begin : g_same
            assign scal = scalar_i;
        end else begin : g_sext
            assign scal = {{(EW-XLEN){scalar_i[XLEN-1]}}, scalar_i};
        end

        if (NE < VLEN) begin : g_mask_rest
            logic unused_mask;
            assign unused_mask = ^mask_i[VLEN-1:NE];
        end

        for (genvar i = 0; i < NE; i++) begin : g_lane
            logic body, active;
            assign body   = (VL_W'(i) < vlen_i);
            assign active = mask_en_n_i | mask_i[i];
            vsmax_lane #(.EW(EW)) u_lane (
                .elem_i      (src_i[i*EW +: EW]),
                .scal_i      (scal),
                .old_i       (old_i[i*EW +: EW]),
                .body_i      (body),
                .active_i    (active),
                .tail_fill_i (tail_fill_i),
                .inact_fill_i(inact_fill_i),
                .res_o       (res_o[i*EW +: EW])
            );
        end
    endgenerate
endmodule

// File: rtl/vsmax_unit.sv
module vsmax_unit
    import vsmax_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int XLEN = 64,
    localparam int MAX_NE = VLEN / MIN_EW,
    localparam int VL_W = $clog2(MAX_NE) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid_i,
    input  logic [VLEN-1:0] src_i,
    input  logic [XLEN-1:0] scalar_i,
    input  logic [VLEN-1:0] old_i,
    input  logic [VLEN-1:0] mask_i,
    input  logic            mask_en_n_i,
    input  logic [VL_W-1:0] vlen_i,
    input  logic [1:0]      sew_i,
    input  logic            tail_fill_i,
    input  logic            inact_fill_i,
    output logic            out_valid_o,
    output logic [VLEN-1:0] vd_o
);
    typedef struct packed {
        logic            vld;
        logic [VLEN-1:0] vd;
    } state_t;

    state_t st_d, st_q;
    logic [VLEN-1:0] grp_res [NUM_SEW];

    generate
        for (genvar g = 0; g < NUM_SEW; g++) begin : g_sew
            vsmax_sew_group #(
                .VLEN(VLEN), .XLEN(XLEN), .EW(lane_bits(g)), .VL_W(VL_W)
            ) u_grp (
                .src_i       (src_i),
                .scalar_i    (scalar_i),
                .old_i       (old_i),
                .mask_i      (mask_i),
                .mask_en_n_i (mask_en_n_i),
                .vlen_i      (vlen_i),
                .tail_fill_i (tail_fill_i),
                .inact_fill_i(inact_fill_i),
                .res_o       (grp_res[g])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid_i;
        if (in_valid_i) begin
            unique case (sew_e'(sew_i))
                SEW_E8:  st_d.vd = grp_res[0];
                SEW_E16: st_d.vd = grp_res[1];
                SEW_E32: st_d.vd = grp_res[2];
                default: st_d.vd = grp_res[3];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.vld;
    assign vd_o        = st_q.vd;
endmodule

// File: rtl/vsmax_chk.sv
module vsmax_chk #(
    parameter int VLEN = 256,
    parameter int XLEN = 64,
    parameter int VL_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid_i,
    input logic [XLEN-1:0] scalar_i,
    input logic [VLEN-1:0] old_i,
    input logic [VLEN-1:0] mask_i,
    input logic            mask_en_n_i,
    input logic [VL_W-1:0] vlen_i,
    input logic [1:0]      sew_i,
    input logic            tail_fill_i,
    input logic            inact_fill_i,
    input logic            out_valid_o,
    input logic [VLEN-1:0] vd_o
);
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> $stable(vd_o));
    a_r4_empty_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && vlen_i == '0 && tail_fill_i) |=> (vd_o == {VLEN{1'b1}}));
    a_r4_empty_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && vlen_i == '0 && !tail_fill_i) |=> (vd_o == $past(old_i)));
    a_r5_all_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !mask_en_n_i && mask_i == '0 && !inact_fill_i && !tail_fill_i)
        |=> (vd_o == $past(old_i)));
    a_r1_max_not_below: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && sew_i == 2'b11 && mask_en_n_i && vlen_i != '0)
        |=> ($signed(vd_o[XLEN-1:0]) >= $signed($past(scalar_i))));
endmodule

bind vsmax_unit vsmax_chk #(.VLEN(VLEN), .XLEN(XLEN), .VL_W(VL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .scalar_i(scalar_i),
    .old_i(old_i), .mask_i(mask_i), .mask_en_n_i(mask_en_n_i), .vlen_i(vlen_i),
    .sew_i(sew_i), .tail_fill_i(tail_fill_i), .inact_fill_i(inact_fill_i),
    .out_valid_o(out_valid_o), .vd_o(vd_o)
);

// File: tb/sim_vsmax_unit.sv
module sim_vsmax_unit;
    localparam int VLEN = 256;
    localparam int XLEN = 64;
    localparam int VL_W = 6;
    localparam int NT   = 8;

    logic            clk = 0, rst_n = 0, in_valid = 0;
    logic [VLEN-1:0] src = '0, old = '0, msk = '0;
    logic [XLEN-1:0] scal = '0;
    logic            men_n = 1, tfill = 0, ifill = 0;
    logic [VL_W-1:0] vl = '0;
    logic [1:0]      sew = '0;
    logic            ov;
    logic [VLEN-1:0] vd;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    vsmax_unit #(.VLEN(VLEN), .XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .src_i(src), .scalar_i(scal),
        .old_i(old), .mask_i(msk), .mask_en_n_i(men_n), .vlen_i(vl), .sew_i(sew),
        .tail_fill_i(tfill), .inact_fill_i(ifill), .out_valid_o(ov), .vd_o(vd));

    // stimulus table: sew, vl, mask_en_n, tail fill, inactive fill, scalar
    localparam logic [1:0]      T_SEW [NT] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b11};
    localparam logic [VL_W-1:0] T_VL  [NT] = '{6'd32, 6'd20, 6'd16, 6'd9, 6'd8, 6'd3, 6'd4, 6'd2};
    localparam logic            T_MEN [NT] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic            T_TF  [NT] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic            T_IF  [NT] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic [XLEN-1:0] T_SC  [NT] = '{
        64'h1234_5678_9ABC_DE7F, 64'hFFFF_FFFF_FFFF_FF80, 64'h0000_0000_0000_8001,
        64'h0000_0000_0000_0010, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_0000_0000,
        64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE};

    function automatic logic [VLEN-1:0] pat(int s);
        logic [VLEN-1:0] p;
        for (int k = 0; k < VLEN/32; k++)
            p[k*32 +: 32] = 32'(s) * 32'h9E37_79B1 + 32'(k) * 32'h7F4A_7C15;
        return p;
    endfunction

    // independent model of the requirements
    function automatic logic [VLEN-1:0] model(logic [1:0] c, logic [VL_W-1:0] l, logic en_n,
            logic tf, logic inf, logic [XLEN-1:0] sc, logic [VLEN-1:0] a,
            logic [VLEN-1:0] o, logic [VLEN-1:0] m);
        int ew = 8 << c;
        int n  = VLEN / ew;
        logic [VLEN-1:0] r = '0;
        logic [63:0] lm = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
        for (int i = 0; i < n; i++) begin
            logic [63:0] e, ov_e, se, ss, v;
            e    = 64'(a >> (i*ew)) & lm;
            ov_e = 64'(o >> (i*ew)) & lm;
            se   = 64'($signed(e << (64-ew)) >>> (64-ew));
            ss   = 64'($signed((sc & lm) << (64-ew)) >>> (64-ew));
            if (i >= int'(l))           v = tf ? lm : ov_e;
            else if (!en_n && !m[i])    v = inf ? lm : ov_e;
            else                        v = ($signed(se) < $signed(ss)) ? (ss & lm) : e;
            r |= VLEN'(v) << (i*ew);
        end
        return r;
    endfunction

    task automatic check(string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run(string tag, logic [1:0] c, logic [VL_W-1:0] l, logic en_n, logic tf,
            logic inf, logic [XLEN-1:0] sc, logic [VLEN-1:0] a, logic [VLEN-1:0] o,
            logic [VLEN-1:0] m);
        @(negedge clk);
        sew = c; vl = l; men_n = en_n; tfill = tf; ifill = inf; scal = sc;
        src = a; old = o; msk = m; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        check({tag, " valid"}, VLEN'(ov), VLEN'(1));
        check(tag, vd, model(c, l, en_n, tf, inf, sc, a, o, m));
    endtask

    initial begin
        #1500000;
        bad++; total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] held;
        repeat (3) @(negedge clk);
        check("R8 reset valid", VLEN'(ov), '0);
        check("R8 reset data", vd, '0);
        rst_n = 1;

        for (int t = 0; t < NT; t++)
            run($sformatf("R1 R2 R3 R4 R5 R6 table%0d", t), T_SEW[t], T_VL[t], T_MEN[t],
                T_TF[t], T_IF[t], T_SC[t], pat(t+1), pat(t+50), pat(t+90));

        // R6: scalar low byte 0x7F is the max for every 8-bit lane
        run("R6 trunc", 2'b00, 6'd32, 1'b1, 1'b0, 1'b0, 64'hFFFF_FF00_0000_017F,
            pat(7), pat(8), '0);
        check("R6 all 7f", vd, {32{8'h7F}});
        // R4: empty length
        run("R4 vl0 ones", 2'b01, 6'd0, 1'b1, 1'b1, 1'b0, 64'd5, pat(3), pat(4), '0);
        check("R4 vl0 ones value", vd, '1);
        run("R4 vl0 keep", 2'b10, 6'd0, 1'b1, 1'b0, 1'b1, 64'd5, pat(3), pat(4), '0);
        check("R4 vl0 keep value", vd, pat(4));
        // R4: clamping length above lane count
        run("R4 clamp", 2'b11, 6'd40, 1'b1, 1'b1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF,
            pat(5), pat(6), '0);
        check("R4 clamp value", vd, {4{64'h7FFF_FFFF_FFFF_FFFF}});
        // R5 / R3: all lanes masked off
        run("R5 masked ones", 2'b00, 6'd32, 1'b0, 1'b0, 1'b1, 64'd0, pat(9), pat(10), '0);
        check("R5 masked ones value", vd, '1);
        run("R3 mask ignored unmasked", 2'b01, 6'd16, 1'b1, 1'b0, 1'b1, 64'd0,
            pat(11), pat(12), '0);
        // R7: hold without request
        held = vd;
        @(negedge clk);
        src = pat(99); old = pat(98);
        @(negedge clk);
        check("R7 no valid", VLEN'(ov), '0);
        check("R7 hold", vd, held);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule